// File: doc/BRIEF.md
# Calendar Time-of-Day Clock with Periodic Interrupt

This block is a byte-wide, memory-mapped calendar clock. It keeps eight time fields: hundredths of a second, hour, minute, second, month, day of month, year and day of week. A timebase pulse that arrives one hundred times a second moves the fields forward, but only while the run bit of the command register is set. A carry passes from the hundredths up through the calendar in the pulse that causes it. A bank of eight compare bytes sits beside the time fields. In this version they are plain storage: they can be written and read back, and they raise no alarm.

A periodic event can be drawn from the carry chain at one of six rates, chosen in the command register. When the event fires and the mask allows it, a sticky pending flag is set. The interrupt output is that flag gated by the interrupt-enable bit. Software clears the flag by reading the interrupt register.

The bus is a plain 8-bit port. The register index is the address shifted right by a parameter, so the registers can sit on a wider stride.

Top module: `tod_clock`

## Requirements
- R1: The register index is `bus_addr >> ADDR_SHIFT`, and the address bits below the shift are ignored. Index 0..7 holds the time fields in this order: hundredths, hour, minute, second, month, day, year, day of week. Index 8..15 holds the compare bytes in the same field order, index 16 is the interrupt register and index 17 is the command register.
- R2: Hundredths count 0..99. On the pulse after 99 the field wraps to 0, and in that same pulse the carry ripples into seconds (0..59), then minutes (0..59), then hours (0..23).
- R3: Time advances on a `tick` pulse only while command bit 3 (run) is 1. While run is 0, every tick is ignored and all time fields hold.
- R4: A read of index 17 (command), or of any index from 18 upward, returns 0xFF.
- R5: A read of index 16 returns {pending in bit 7, mask in bits 6:0}. The same access clears the pending flag and keeps the mask.
- R6: A write to index 16 loads the mask from data bits 6:0 and forces the pending flag to 0.
- R7: `irq` equals the pending flag AND command bit 4 (interrupt enable). When the enable changes, the output follows in the same cycle.
- R8: Command bits 2:0 select the periodic event. The codes are 0 = every tick, 1 = every tenth of a second (when hundredths roll from 9 to 10, 19 to 20, and so on), 2 = every second, 3 = every minute, 4 = every hour, 5 = every day. Codes 6 and 7 select no event. An event sets the pending flag only when mask bit 0 is 1.
- R9: When hour wraps from 23 to 0, the day and the day of week advance, and the day of week wraps from 6 to 0. A day past the month length becomes 1 and the month advances. Month 12 wraps to 1 and the year advances. Months 4, 6, 9 and 11 have 30 days. February has 29 days when (BASE_YEAR + year) mod 4 is 0, and 28 days otherwise. All other months have 31 days.
- R10: A write to index 0..15 loads the addressed byte. When a time-field write falls in the same cycle as a tick, the write wins and that tick is dropped for all time fields.
- R11: When a read of the interrupt register and a periodic event fall in the same cycle, the read returns the old value and the pending flag ends set.
- R12: After reset, the time fields read hundredths/hour/minute/second 0, month 1, day 1, year 0 and day of week 0. The compare bytes read 0, the interrupt register reads 0x00, the command register is 0 (stopped) and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse, one hundred per second |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; the index is taken after the shift |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| irq | output | 1 | Periodic interrupt request |

## Verification
Two pairs of functions can meet in one cycle. A read that clears the pending flag can meet a periodic event that sets it, and a bus write to a time field can meet a timebase pulse. The bench provokes each pair by asserting the bus strobe and `tick` on the same falling edge. It then judges the result through the ports. For the first pair, the read data must show the flag still clear and `irq` must be high afterwards. For the second pair, the written byte must be present and the neighbouring field must be unchanged.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int NUM_TIME = 8;
  localparam int IDX_W    = 5;
  localparam int IDX_INT  = 16;
  localparam int IDX_CMD  = 17;

  localparam int F_CSEC = 0;
  localparam int F_HOUR = 1;
  localparam int F_MIN  = 2;
  localparam int F_SEC  = 3;
  localparam int F_MON  = 4;
  localparam int F_DAY  = 5;
  localparam int F_YEAR = 6;
  localparam int F_DOW  = 7;

  localparam int CMD_RUN_BIT = 3;
  localparam int CMD_IE_BIT  = 4;

  typedef enum logic [2:0] {
    RATE_CENTI = 3'd0,
    RATE_DECI  = 3'd1,
    RATE_SEC   = 3'd2,
    RATE_MIN   = 3'd3,
    RATE_HOUR  = 3'd4,
    RATE_DAY   = 3'd5
  } rate_e;

  // Next value of a cyclic field: wraps to 'first' once 'last' is reached.
  function automatic logic [7:0] step(input logic [7:0] v, input logic [7:0] last,
                                      input logic [7:0] first);
    return (v >= last) ? first : v + 8'd1;
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yoff,
                                            input int base);
    logic leap;
    leap = ((base + int'(yoff)) % 4) == 0;
    case (mon)
      8'd2:                    return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int i);
    return (i == F_MON || i == F_DAY) ? 8'd1 : 8'd0;
  endfunction
endpackage

// File: rtl/tod_time.sv
`timescale 1ns/1ps
module tod_time
  import tod_pkg::*;
#(
  parameter int BASE_YEAR = 1968
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv_i,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_sel_i,
  input  logic [7:0]  wr_data_i,
  output logic [63:0] fields_o,
  output logic        cs_wrap_o,
  output logic        sec_wrap_o,
  output logic        min_wrap_o,
  output logic        hr_wrap_o
);
  logic [7:0] f_q [NUM_TIME];
  logic [7:0] f_d [NUM_TIME];
  logic [7:0] dim;
  logic       day_wrap, mon_wrap;

  assign dim        = month_days(f_q[F_MON], f_q[F_YEAR], BASE_YEAR);
  assign cs_wrap_o  = f_q[F_CSEC] >= 8'd99;
  assign sec_wrap_o = cs_wrap_o  && (f_q[F_SEC]  >= 8'd59);
  assign min_wrap_o = sec_wrap_o && (f_q[F_MIN]  >= 8'd59);
  assign hr_wrap_o  = min_wrap_o && (f_q[F_HOUR] >= 8'd23);
  assign day_wrap   = hr_wrap_o  && (f_q[F_DAY]  >= dim);
  assign mon_wrap   = day_wrap   && (f_q[F_MON]  >= 8'd12);

  always_comb begin
    f_d = f_q;
    if (wr_en_i) begin
      f_d[wr_sel_i] = wr_data_i;
    end else if (adv_i) begin
      f_d[F_CSEC] = step(f_q[F_CSEC], 8'd99, 8'd0);
      if (cs_wrap_o)  f_d[F_SEC]  = step(f_q[F_SEC], 8'd59, 8'd0);
      if (sec_wrap_o) f_d[F_MIN]  = step(f_q[F_MIN], 8'd59, 8'd0);
      if (min_wrap_o) f_d[F_HOUR] = step(f_q[F_HOUR], 8'd23, 8'd0);
      if (hr_wrap_o) begin
        f_d[F_DAY] = step(f_q[F_DAY], dim, 8'd1);
        f_d[F_DOW] = step(f_q[F_DOW], 8'd6, 8'd0);
      end
      if (day_wrap)   f_d[F_MON]  = step(f_q[F_MON], 8'd12, 8'd1);
      if (mon_wrap)   f_d[F_YEAR] = f_q[F_YEAR] + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIME; i++) f_q[i] <= field_reset(i);
    end else begin
      f_q <= f_d;
    end
  end

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_flat
    assign fields_o[g*8 +: 8] = f_q[g];
  end

  AST_CSEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_en_i && fields_o[7:0] >= 8'd99) |=> fields_o[7:0] == 8'd0); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !wr_en_i) |=> $stable(fields_o)); // R3
endmodule

// File: rtl/tod_periodic.sv
`timescale 1ns/1ps
module tod_periodic
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic [2:0] rate_i,
  input  logic [7:0] cs_i,
  input  logic       cs_wrap_i,
  input  logic       sec_wrap_i,
  input  logic       min_wrap_i,
  input  logic       hr_wrap_i,
  input  logic       mask_wr_i,
  input  logic [6:0] mask_data_i,
  input  logic       rd_clr_i,
  output logic       pending_o,
  output logic [6:0] mask_o,
  output logic       evt_o
);
  logic hit;
  logic set_pend;

  always_comb begin
    case (rate_i)
      RATE_CENTI: hit = 1'b1;
      RATE_DECI:  hit = (cs_i % 8'd10) == 8'd9;
      RATE_SEC:   hit = cs_wrap_i;
      RATE_MIN:   hit = sec_wrap_i;
      RATE_HOUR:  hit = min_wrap_i;
      RATE_DAY:   hit = hr_wrap_i;
      default:    hit = 1'b0;
    endcase
  end

  assign evt_o    = adv_i && hit;
  assign set_pend = evt_o && mask_o[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_o <= 1'b0;
      mask_o    <= '0;
    end else begin
      if (mask_wr_i) mask_o <= mask_data_i;
      if (set_pend) pending_o <= 1'b1;
      else if (rd_clr_i || mask_wr_i) pending_o <= 1'b0;
    end
  end

  AST_EVT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && mask_o[0] && !mask_wr_i) |=> pending_o); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !evt_o) |=> !pending_o); // R5
endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
  import tod_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int ADDR_SHIFT = 1,
  parameter int BASE_YEAR  = 1968
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  logic [IDX_W-1:0] idx;
  logic             acc_wr, acc_rd, time_wr, cmp_wr, adv;
  logic [7:0]       cmd_q;
  logic [7:0]       cmp_q [NUM_TIME];
  logic [63:0]      fields;
  logic             cs_wrap, sec_wrap, min_wrap, hr_wrap;
  logic             pending, evt;
  logic [6:0]       mask;

  assign idx     = IDX_W'(bus_addr >> ADDR_SHIFT);
  assign acc_wr  = bus_sel && bus_wr;
  assign acc_rd  = bus_sel && !bus_wr;
  assign time_wr = acc_wr && (idx < IDX_W'(NUM_TIME));
  assign cmp_wr  = acc_wr && (idx >= IDX_W'(NUM_TIME)) && (idx < IDX_W'(2*NUM_TIME));
  assign adv     = tick && cmd_q[CMD_RUN_BIT] && !time_wr;

  tod_time #(.BASE_YEAR(BASE_YEAR)) u_time (
    .clk, .rst_n, .adv_i(adv), .wr_en_i(time_wr), .wr_sel_i(idx[2:0]),
    .wr_data_i(bus_wdata), .fields_o(fields), .cs_wrap_o(cs_wrap),
    .sec_wrap_o(sec_wrap), .min_wrap_o(min_wrap), .hr_wrap_o(hr_wrap)
  );

  tod_periodic u_per (
    .clk, .rst_n, .adv_i(adv), .rate_i(cmd_q[2:0]), .cs_i(fields[7:0]),
    .cs_wrap_i(cs_wrap), .sec_wrap_i(sec_wrap), .min_wrap_i(min_wrap),
    .hr_wrap_i(hr_wrap),
    .mask_wr_i(acc_wr && idx == IDX_W'(IDX_INT)), .mask_data_i(bus_wdata[6:0]),
    .rd_clr_i(acc_rd && idx == IDX_W'(IDX_INT)),
    .pending_o(pending), .mask_o(mask), .evt_o(evt)
  );

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n) cmp_q[g] <= 8'd0;
      else if (cmp_wr && idx[2:0] == 3'(g)) cmp_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= 8'd0;
    else if (acc_wr && idx == IDX_W'(IDX_CMD)) cmd_q <= bus_wdata;
  end

  always_comb begin
    if (idx < IDX_W'(NUM_TIME))        bus_rdata = fields[{idx[2:0], 3'b000} +: 8];
    else if (idx < IDX_W'(2*NUM_TIME)) bus_rdata = cmp_q[idx[2:0]];
    else if (idx == IDX_W'(IDX_INT))   bus_rdata = {pending, mask};
    else                               bus_rdata = 8'hFF;
  end

  assign irq = pending && cmd_q[CMD_IE_BIT];

  AST_CMD_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && idx >= IDX_W'(IDX_CMD)) |-> bus_rdata == 8'hFF); // R4
  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mask[0] && acc_rd) |=> pending); // R11
endmodule

// File: tb/tod_clock_test.sv
`timescale 1ns/1ps
module tod_clock_test;
  localparam int AW = 6;
  localparam int SH = 1;

  logic clk = 0, rst_n = 0, tick = 0, bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  tod_clock #(.ADDR_W(AW), .ADDR_SHIFT(SH), .BASE_YEAR(1968)) uut (
    .clk, .rst_n, .tick, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(i << SH); bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int i, output logic [7:0] d, input int lo = 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'((i << SH) | lo);
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(posedge clk); #1 tick = 0;
  endtask

  task automatic set_time(input int cs, hr, mn, sc, mo, dy, yr, dw);
    wr(0, 8'(cs)); wr(1, 8'(hr)); wr(2, 8'(mn)); wr(3, 8'(sc));
    wr(4, 8'(mo)); wr(5, 8'(dy)); wr(6, 8'(yr)); wr(7, 8'(dw));
  endtask

  function automatic int exp_dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    return 30 + ((m + m / 8) % 2);
  endfunction

  task automatic freq_case(input int f, cs, sc, mn, hr, input bit fire, input string req);
    logic [7:0] d;
    wr(17, 8'(8'h18 | f));
    wr(16, 8'h01);
    set_time(cs, hr, mn, sc, 3, 10, 1, 2);
    pulse();
    @(negedge clk);
    chk(req, {7'd0, irq}, {7'd0, fire});
    rd(16, d);
    chk(req, d, fire ? 8'h81 : 8'h01);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset state
    for (int i = 0; i < 16; i++) begin
      rd(i, d);
      chk("R12", d, (i == 4 || i == 5) ? 8'd1 : 8'd0);
    end
    rd(16, d); chk("R12", d, 8'h00);
    chk("R12", {7'd0, irq}, 8'd0);

    // R4 command and undefined indices read as ones
    for (int i = 17; i < 32; i++) begin
      rd(i, d); chk("R4", d, 8'hFF);
    end

    // R10/R1 compare bank loads, time untouched, low address bit ignored
    for (int i = 8; i < 16; i++) wr(i, 8'(8'hA0 + i));
    for (int i = 8; i < 16; i++) begin
      rd(i, d, 1); chk("R1", d, 8'(8'hA0 + i));
    end
    rd(0, d); chk("R10", d, 8'd0);

    // R3 stopped clock ignores ticks
    set_time(7, 1, 2, 3, 4, 5, 6, 0);
    repeat (3) pulse();
    rd(0, d); chk("R3", d, 8'd7);
    rd(3, d); chk("R3", d, 8'd3);

    // R2 hundredths sweep with carry into seconds
    wr(17, 8'h08);
    for (int c = 0; c < 100; c++) begin
      wr(0, 8'(c)); wr(3, 8'd0);
      pulse();
      rd(0, d); chk("R2", d, 8'((c + 1) % 100));
      rd(3, d); chk("R2", d, (c == 99) ? 8'd1 : 8'd0);
    end
    set_time(99, 22, 59, 59, 3, 10, 1, 2);
    pulse();
    rd(1, d); chk("R2", d, 8'd23);
    rd(2, d); chk("R2", d, 8'd0);

    // R9 month-end sweep over four years
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_time(99, 23, 59, 59, m, exp_dim(m, y), y, 6);
        pulse();
        rd(5, d); chk("R9", d, 8'd1);
        rd(4, d); chk("R9", d, 8'((m == 12) ? 1 : m + 1));
        rd(6, d); chk("R9", d, 8'((m == 12) ? y + 1 : y));
        rd(7, d); chk("R9", d, 8'd0);
        rd(1, d); chk("R9", d, 8'd0);
      end
      set_time(99, 23, 59, 59, 2, 28, y, 3);
      pulse();
      rd(5, d); chk("R9", d, (y % 4 == 0) ? 8'd29 : 8'd1);
      rd(7, d); chk("R9", d, 8'd4);
    end

    // R8 periodic rates
    freq_case(0, 40, 10, 10, 10, 1, "R8");
    freq_case(1, 8, 10, 10, 10, 0, "R8");
    freq_case(1, 9, 10, 10, 10, 1, "R8");
    freq_case(2, 98, 10, 10, 10, 0, "R8");
    freq_case(2, 99, 10, 10, 10, 1, "R8");
    freq_case(3, 99, 58, 10, 10, 0, "R8");
    freq_case(3, 99, 59, 10, 10, 1, "R8");
    freq_case(4, 99, 59, 59, 10, 1, "R8");
    freq_case(4, 99, 59, 58, 10, 0, "R8");
    freq_case(5, 99, 59, 59, 23, 1, "R8");
    freq_case(5, 99, 59, 59, 22, 0, "R8");
    freq_case(6, 99, 59, 59, 23, 0, "R8");

    // R5 read clears pending, keeps mask
    wr(17, 8'h18); wr(16, 8'h05);
    pulse();
    rd(16, d); chk("R5", d, 8'h85);
    rd(16, d); chk("R5", d, 8'h05);

    // R6 mask write forces pending low; mask bit 0 gates events
    pulse();
    wr(16, 8'hFF);
    rd(16, d); chk("R6", d, 8'h7F);
    wr(16, 8'h00);
    pulse();
    rd(16, d); chk("R6", d, 8'h00);

    // R7 enable gates the output
    wr(17, 8'h08); wr(16, 8'h01);
    pulse();
    @(negedge clk); chk("R7", {7'd0, irq}, 8'd0);
    wr(17, 8'h18);
    @(negedge clk); chk("R7", {7'd0, irq}, 8'd1);
    wr(17, 8'h08);
    @(negedge clk); chk("R7", {7'd0, irq}, 8'd0);

    // R11 read and event in the same cycle
    wr(17, 8'h18); rd(16, d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(16 << SH); tick = 1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0; tick = 0;
    chk("R11", d, 8'h01);
    @(negedge clk); chk("R11", {7'd0, irq}, 8'd1);
    rd(16, d); chk("R11", d, 8'h81);

    // R10 time write beats a tick
    set_time(5, 4, 4, 3, 5, 5, 5, 5);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(0); bus_wdata = 8'd40; tick = 1;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0; tick = 0;
    rd(0, d); chk("R10", d, 8'd40);
    rd(3, d); chk("R10", d, 8'd3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule